// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block divides one integer by another over many clock cycles and returns both the quotient and the remainder. It works on 64-bit operands, or on 32-bit operands taken from the low half of each input word. Each operation can be signed or unsigned. Inside, a shift-and-add/subtract recurrence settles one quotient bit per clock. At each step it adds the divisor to the partial remainder or subtracts it, depending on the remainder's current sign, and it never restores.

The unit runs one operation at a time. A caller raises `start_i` for one cycle while `busy_o` is low. The block then holds `busy_o` high and ignores any further start request. When the result is ready it pulses `done_o` for exactly one cycle. The result outputs then keep their values until the next operation finishes.

The control is a five-state machine:
- `ST_IDLE`: waiting for a request.
- `ST_SETUP`: takes absolute values and aligns the dividend.
- `ST_ITER`: runs one recurrence step per cycle, 32 or 64 of them.
- `ST_CORRECT`: adds the divisor back when the final partial remainder is negative.
- `ST_FIXUP`: applies the signs, extends narrow results and registers the outputs.

The transitions are:
- `ST_IDLE` to `ST_SETUP` on a start request.
- `ST_SETUP` to `ST_ITER`, always.
- `ST_ITER` back to itself until its step count reaches its last step, then to `ST_CORRECT`.
- `ST_CORRECT` to `ST_FIXUP`, always.
- `ST_FIXUP` to `ST_IDLE` with `done_o`.

Top module: `iter_divider`

## Requirements
- R1: A start request is accepted only while `busy_o` is low. In the cycle after the accepting clock edge `busy_o` is high, and it stays high until the result is delivered. A start request raised while busy is ignored: it produces no extra result and does not disturb the one in flight.
- R2: With `wide_i`=0 (32-bit mode), `done_o` is high in the cycle that follows the 35th rising edge after the edge that accepted the start, counting the accepting edge as edge 0.
- R3: With `wide_i`=1 (64-bit mode), `done_o` is high in the cycle that follows the 67th rising edge after the accepting edge.
- R4: `done_o` is high for exactly one cycle per accepted operation.
- R5: In 64-bit unsigned mode (`signed_i`=0) with a nonzero divisor, quotient × divisor + remainder equals the dividend, and the remainder is less than the divisor.
- R6: In signed mode (`signed_i`=1), division truncates toward zero. The quotient is negative when the operand signs differ, and a nonzero remainder has the sign of the dividend. Operands and results are two's complement.
- R7: In 32-bit mode only bits [31:0] of each operand are used. The 32-bit quotient and remainder are sign-extended to 64 bits in signed mode and zero-extended in unsigned mode.
- R8: A zero divisor (bits [31:0] in 32-bit mode) completes with the normal latency. It sets `div_zero_o`, returns a quotient of all 64 ones, and returns a remainder equal to the dividend, extended as in R7. `div_zero_o` is low for any result with a nonzero divisor.
- R9: `quotient_o`, `remainder_o` and `div_zero_o` change only in a cycle where `done_o` is high, and otherwise hold their values.
- R10: During and right after reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a division (taken only while idle) |
| wide_i | input | 1 | 1 selects 64-bit operands, 0 selects the low 32 bits |
| signed_i | input | 1 | 1 selects two's-complement operands |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| quotient_o | output | 64 | Registered quotient |
| remainder_o | output | 64 | Registered remainder |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle pulse: results are valid |
| div_zero_o | output | 1 | The delivered result came from a zero divisor |

## Verification
The following are checked on every cycle:
- the busy handshake and its hand-off into the done pulse;
- the exact 35-cycle and 67-cycle start-to-done distance, measured by a counter;
- the single-cycle done pulse;
- the hold of the outputs between results;
- the all-ones quotient under a zero divisor;
- the arithmetic identity for wide unsigned results.

Some behaviour only the bench's scenarios can show. These are signed truncation with every sign mix, narrow-mode extension with junk in the upper operand bits, the remainder under a zero divisor, and a start request dropped in the middle of an operation.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_CORRECT,
        ST_FIXUP
    } div_state_e;

endpackage

// File: rtl/div_setup.sv
// Operand preparation: magnitudes, sign bookkeeping and dividend alignment.
module div_setup #(
    parameter int XLEN = 64
) (
    input  logic            wide_i,
    input  logic            sgn_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] q_init_o,
    output logic [XLEN-1:0] b_mag_o,
    output logic            neg_q_o,
    output logic            neg_r_o,
    output logic            dz_o
);
    localparam int HALF = XLEN / 2;

    logic            neg_a, neg_b;
    logic [XLEN-1:0] a_sel, b_sel, a_neg, b_neg, a_mag;

    always_comb begin
        neg_a = sgn_i & (wide_i ? a_i[XLEN-1] : a_i[HALF-1]);
        neg_b = sgn_i & (wide_i ? b_i[XLEN-1] : b_i[HALF-1]);
        a_sel = wide_i ? a_i : {{HALF{1'b0}}, a_i[HALF-1:0]};
        b_sel = wide_i ? b_i : {{HALF{1'b0}}, b_i[HALF-1:0]};
        a_neg = '0 - a_sel;
        b_neg = '0 - b_sel;

        if (neg_a)
            a_mag = wide_i ? a_neg : {{HALF{1'b0}}, a_neg[HALF-1:0]};
        else
            a_mag = a_sel;

        if (neg_b)
            b_mag_o = wide_i ? b_neg : {{HALF{1'b0}}, b_neg[HALF-1:0]};
        else
            b_mag_o = b_sel;

        // Narrow operands sit in the upper half so the MSB shifts out first.
        q_init_o = wide_i ? a_mag : {a_mag[HALF-1:0], {HALF{1'b0}}};
        neg_q_o  = neg_a ^ neg_b;
        neg_r_o  = neg_a;
        dz_o     = (b_sel == '0);
    end
endmodule

// File: rtl/div_step.sv
// One non-restoring recurrence step on a signed partial remainder.
module div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN+1:0] p_i,
    input  logic [XLEN-1:0] q_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN+1:0] p_o,
    output logic [XLEN-1:0] q_o
);
    logic [XLEN+1:0] shifted, b_ext;

    always_comb begin
        shifted = {p_i[XLEN:0], q_i[XLEN-1]};
        b_ext   = {2'b00, b_i};
        if (p_i[XLEN+1])
            p_o = shifted + b_ext;
        else
            p_o = shifted - b_ext;
        q_o = {q_i[XLEN-2:0], ~p_o[XLEN+1]};
    end
endmodule

// File: rtl/div_fixup.sv
// Sign application, narrow-result extension and zero-divisor override.
module div_fixup #(
    parameter int XLEN = 64
) (
    input  logic            wide_i,
    input  logic            sgn_i,
    input  logic            neg_q_i,
    input  logic            neg_r_i,
    input  logic            dz_i,
    input  logic [XLEN-1:0] q_mag_i,
    input  logic [XLEN-1:0] r_mag_i,
    input  logic [XLEN-1:0] a_raw_i,
    output logic [XLEN-1:0] quot_o,
    output logic [XLEN-1:0] rem_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] q_s, r_s, q_x, r_x, a_x;

    always_comb begin
        q_s = neg_q_i ? ('0 - q_mag_i) : q_mag_i;
        r_s = neg_r_i ? ('0 - r_mag_i) : r_mag_i;

        if (wide_i) begin
            q_x = q_s;
            r_x = r_s;
            a_x = a_raw_i;
        end else if (sgn_i) begin
            q_x = {{HALF{q_s[HALF-1]}}, q_s[HALF-1:0]};
            r_x = {{HALF{r_s[HALF-1]}}, r_s[HALF-1:0]};
            a_x = {{HALF{a_raw_i[HALF-1]}}, a_raw_i[HALF-1:0]};
        end else begin
            q_x = {{HALF{1'b0}}, q_s[HALF-1:0]};
            r_x = {{HALF{1'b0}}, r_s[HALF-1:0]};
            a_x = {{HALF{1'b0}}, a_raw_i[HALF-1:0]};
        end

        quot_o = dz_i ? '1  : q_x;
        rem_o  = dz_i ? a_x : r_x;
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
    parameter int XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            wide_i,
    input  logic            signed_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    output logic [XLEN-1:0] quotient_o,
    output logic [XLEN-1:0] remainder_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            div_zero_o
);
    import div_pkg::*;

    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN + 1);

    div_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [XLEN-1:0] a_q, b_q;
    logic            wide_q, sgn_q;
    logic [XLEN+1:0] p_q;
    logic [XLEN-1:0] q_q, bm_q;
    logic            negq_q, negr_q, dz_q;
    logic [XLEN-1:0] quot_q, rem_q;
    logic            done_q, dzo_q;

    logic [XLEN-1:0] q_init, b_mag;
    logic            neg_q, neg_r, dz;
    logic [XLEN+1:0] p_step;
    logic [XLEN-1:0] q_step;
    logic [XLEN-1:0] quot_fix, rem_fix;

    div_setup #(.XLEN(XLEN)) setup_i (
        .wide_i  (wide_q),
        .sgn_i   (sgn_q),
        .a_i     (a_q),
        .b_i     (b_q),
        .q_init_o(q_init),
        .b_mag_o (b_mag),
        .neg_q_o (neg_q),
        .neg_r_o (neg_r),
        .dz_o    (dz)
    );

    div_step #(.XLEN(XLEN)) step_i (
        .p_i(p_q),
        .q_i(q_q),
        .b_i(bm_q),
        .p_o(p_step),
        .q_o(q_step)
    );

    div_fixup #(.XLEN(XLEN)) fixup_i (
        .wide_i (wide_q),
        .sgn_i  (sgn_q),
        .neg_q_i(negq_q),
        .neg_r_i(negr_q),
        .dz_i   (dz_q),
        .q_mag_i(q_q),
        .r_mag_i(p_q[XLEN-1:0]),
        .a_raw_i(a_q),
        .quot_o (quot_fix),
        .rem_o  (rem_fix)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_ITER;
            ST_ITER:    if (cnt_q == CNT_W'(1)) state_d = ST_CORRECT;
            ST_CORRECT: state_d = ST_FIXUP;
            ST_FIXUP:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
            wide_q <= 1'b0;
            sgn_q  <= 1'b0;
            p_q    <= '0;
            q_q    <= '0;
            bm_q   <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        a_q    <= dividend_i;
                        b_q    <= divisor_i;
                        wide_q <= wide_i;
                        sgn_q  <= signed_i;
                    end
                end
                ST_SETUP: begin
                    p_q    <= '0;
                    q_q    <= q_init;
                    bm_q   <= b_mag;
                    negq_q <= neg_q;
                    negr_q <= neg_r;
                    dz_q   <= dz;
                    cnt_q  <= wide_q ? CNT_W'(XLEN) : CNT_W'(HALF);
                end
                ST_ITER: begin
                    p_q   <= p_step;
                    q_q   <= q_step;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_CORRECT: begin
                    if (p_q[XLEN+1]) p_q <= p_q + {2'b00, bm_q};
                end
                ST_FIXUP: ;
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            quot_q <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
            dzo_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIXUP);
            if (state_q == ST_FIXUP) begin
                quot_q <= quot_fix;
                rem_q  <= rem_fix;
                dzo_q  <= dz_q;
            end
        end
    end

    assign quotient_o  = quot_q;
    assign remainder_o = rem_q;
    assign done_o      = done_q;
    assign div_zero_o  = dzo_q;
    assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk #(
    parameter int XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            wide_i,
    input logic            signed_i,
    input logic [XLEN-1:0] dividend_i,
    input logic [XLEN-1:0] divisor_i,
    input logic [XLEN-1:0] quotient_o,
    input logic [XLEN-1:0] remainder_o,
    input logic            busy_o,
    input logic            done_o,
    input logic            div_zero_o
);
    localparam int HALF = XLEN / 2;

    int unsigned     lat_cnt;
    logic            op_wide, op_sgn;
    logic [XLEN-1:0] op_a, op_b;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lat_cnt <= 0;
            op_wide <= 1'b0;
            op_sgn  <= 1'b0;
            op_a    <= '0;
            op_b    <= '0;
        end else if (start_i && !busy_o) begin
            lat_cnt <= 0;
            op_wide <= wide_i;
            op_sgn  <= signed_i;
            op_a    <= dividend_i;
            op_b    <= divisor_i;
        end else begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R1
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o); // R1
    AST_LAT_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !op_wide) |-> (lat_cnt == HALF + 3)); // R2
    AST_LAT_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && op_wide) |-> (lat_cnt == XLEN + 3)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R4
    AST_UNSIGNED_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && op_wide && !op_sgn && op_b != '0) |->
        ((quotient_o * op_b + remainder_o == op_a) && (remainder_o < op_b))); // R5
    AST_DZ_QUOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && div_zero_o) |-> (&quotient_o)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o))); // R9
endmodule

bind iter_divider iter_divider_chk #(.XLEN(XLEN)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wide_i     (wide_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o)
);

// File: tb/iter_divider_tb_top.sv
`timescale 1ns/1ps
module iter_divider_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0, sgn = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic [63:0] quot, rem;
    logic        busy, done, dzf;

    always #4 clk = ~clk;

    iter_divider dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide), .signed_i(sgn),
        .dividend_i(a), .divisor_i(b), .quotient_o(quot), .remainder_o(rem),
        .busy_o(busy), .done_o(done), .div_zero_o(dzf)
    );

    typedef struct {
        logic [63:0] q;
        logic [63:0] r;
        logic        dz;
        logic        w;
        logic        s;
        int unsigned t0;
    } exp_t;

    exp_t        sb[$];
    int          tests = 0, fails = 0;
    int unsigned edge_no = 0;
    bit          finished = 1'b0;

    always @(posedge clk) edge_no <= edge_no + 1;

    function automatic logic [63:0] ext32(logic [31:0] v, logic s);
        return s ? {{32{v[31]}}, v} : {32'h0, v};
    endfunction

    function automatic exp_t model(logic w, logic s, logic [63:0] x, logic [63:0] y);
        exp_t e;
        logic [31:0] x32, y32, q32, r32;
        e.w = w; e.s = s; e.t0 = 0;
        if (w) begin
            e.dz = (y == 64'h0);
            if (e.dz) begin e.q = '1; e.r = x; end
            else if (s) begin e.q = $signed(x) / $signed(y); e.r = $signed(x) % $signed(y); end
            else begin e.q = x / y; e.r = x % y; end
        end else begin
            x32 = x[31:0]; y32 = y[31:0];
            e.dz = (y32 == 32'h0);
            if (e.dz) begin e.q = '1; e.r = ext32(x32, s); end
            else begin
                if (s) begin q32 = $signed(x32) / $signed(y32); r32 = $signed(x32) % $signed(y32); end
                else begin q32 = x32 / y32; r32 = x32 % y32; end
                e.q = ext32(q32, s); e.r = ext32(r32, s);
            end
        end
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic run_div(logic w, logic s, logic [63:0] x, logic [63:0] y);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e = model(w, s, x, y);
        e.t0 = edge_no + 1;
        sb.push_back(e);
        start = 1'b1; wide = w; sgn = s; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        check("R1 busy after accepted start", {63'h0, busy}, 64'h1);
    endtask

    // Monitor: compare each delivered result with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                tests++; fails++;
                $display("FAIL R1 unexpected result: actual %h expected none", quot);
            end else begin
                exp_t e;
                string tq;
                e = sb.pop_front();
                tq = e.w ? (e.s ? "R6 quotient" : "R5 quotient") : "R7 quotient";
                check(e.dz ? "R8 quotient" : tq, quot, e.q);
                check(e.dz ? "R8 remainder" : (e.w ? (e.s ? "R6 remainder" : "R5 remainder") : "R7 remainder"), rem, e.r);
                check("R8 zero flag", {63'h0, dzf}, {63'h0, e.dz});
                check(e.w ? "R3 latency" : "R2 latency", 64'(edge_no - e.t0), e.w ? 64'd67 : 64'd35);
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] hq, hr;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy in reset", {63'h0, busy}, 64'h0);
        check("R10 done in reset", {63'h0, done}, 64'h0);
        check("R10 outputs in reset", quot | rem, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 flag after reset", {62'h0, dzf, busy}, 64'h0);

        // R5 unsigned 64-bit
        run_div(1, 0, 64'd1000, 64'd7);
        run_div(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        run_div(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_div(1, 0, 64'd5, 64'd9);
        run_div(1, 0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0001);
        // R6 signed 64-bit, every sign mix
        run_div(1, 1, 64'hFFFF_FFFF_FFFF_FF9C, 64'd7);
        run_div(1, 1, 64'd100, 64'hFFFF_FFFF_FFFF_FFF9);
        run_div(1, 1, 64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFF9);
        run_div(1, 1, 64'h8000_0000_0000_0000, 64'd2);
        // R7 narrow mode with junk in upper operand bits
        run_div(0, 0, 64'hDEAD_BEEF_0000_0064, 64'hFFFF_0000_0000_0007);
        run_div(0, 0, 64'h0123_4567_FFFF_FFFF, 64'h0000_0001_0000_0002);
        run_div(0, 1, 64'h5555_5555_FFFF_FF9C, 64'hAAAA_AAAA_0000_0007);
        run_div(0, 1, 64'h0000_0000_0000_0064, 64'h1111_1111_FFFF_FFF9);
        // R8 zero divisor in both widths and both modes
        run_div(1, 0, 64'd77, 64'd0);
        run_div(1, 1, 64'hFFFF_FFFF_FFFF_FFFB, 64'd0);
        run_div(0, 1, 64'h7777_0000_8000_0005, 64'hABCD_0000_0000_0000);
        run_div(0, 0, 64'h7777_0000_8000_0005, 64'hABCD_0000_0000_0000);
        run_div(1, 0, 64'd81, 64'd9);

        // R1: start raised while busy is ignored
        run_div(1, 0, 64'd999, 64'd10);
        repeat (5) @(negedge clk);
        start = 1'b1; a = 64'd1; b = 64'd1; wide = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R1 busy holds during ignored start", {63'h0, busy}, 64'h1);

        // R4 / R9: pulse width and hold after the last result
        while (!done) @(negedge clk);
        hq = quot; hr = rem;
        @(negedge clk);
        check("R4 done falls after one cycle", {63'h0, done}, 64'h0);
        repeat (10) @(negedge clk);
        check("R9 quotient holds", quot, hq);
        check("R9 remainder holds", rem, hr);
        check("R1 no extra result pending", 64'(sb.size()), 64'h0);
        check("R1 idle after ignored start", {63'h0, busy}, 64'h0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule